// File: doc/BRIEF.md
# Microprogram Sequencer with Opcode Dispatch

This block holds the micro-program counter of a microcoded processor and chooses its next value on every clock. The control store supplies a next-address field for the current micro-address. By default the sequencer follows that field. Two skip-style conditional controls test the zero flag: when the test fails, the sequencer falls through to the following micro-address. A dispatch control replaces the next address with an entry from a table indexed by the 8-bit opcode of the current instruction.

A dispatch entry of zero marks an opcode that has no microcode. Using such an entry raises a sticky error. Micro-address zero is the end of every macro-instruction, and the block signals each arrival there. The control store and the dispatch table are filled through two plain synchronous write ports. Other fields of the microword are decoded outside this block.

Top module: `micro_sequencer`

## Requirements
- R1: A clock edge with `rst_n` low sets `upc` to 0 and clears `instr_done` and `illegal_op`. It also clears every control-store word and every dispatch-table entry to 0, so any dispatch made before reloading is illegal.
- R2: With no control input asserted, the next `upc` is the control-store word stored at the current `upc`.
- R3: With `cond_nz_en` asserted, the next `upc` is the stored word when `z_flag` is 0. When `z_flag` is 1 it is `upc`+1, which wraps from 255 to 0.
- R4: With `cond_z_en` asserted, the next `upc` is the stored word when `z_flag` is 1. When `z_flag` is 0 it is `upc`+1, with the same wrap.
- R5: With `dispatch_en` asserted, the next `upc` is the dispatch-table entry at index `opcode`.
- R6: A dispatch that reads an entry of 0 loads `upc` with 0 and sets `illegal_op` on the same edge.
- R7: Once set, `illegal_op` stays high until a reset edge.
- R8: `instr_done` is high for exactly those cycles that follow a non-reset edge which loaded 0 into `upc`. It is low in every other cycle.
- R9: `dispatch_en` overrides both conditional controls. When both conditional controls are asserted without dispatch, `cond_nz_en` decides.
- R10: A write takes effect at the clock edge. A read of the same word in that cycle still returns the old contents.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| z_flag | input | 1 | Zero flag from the datapath |
| opcode | input | 8 | Opcode of the current instruction, indexes the dispatch table |
| dispatch_en | input | 1 | Take the next address from the dispatch table |
| cond_nz_en | input | 1 | Follow the field only when z_flag is 0, else step by one |
| cond_z_en | input | 1 | Follow the field only when z_flag is 1, else step by one |
| cs_wr_en | input | 1 | Control-store write strobe |
| cs_wr_addr | input | 8 | Control-store write address |
| cs_wr_data | input | 8 | Next-address field to store |
| dt_wr_en | input | 1 | Dispatch-table write strobe |
| dt_wr_addr | input | 8 | Dispatch-table write index (opcode) |
| dt_wr_data | input | 8 | Micro-address entry, 0 meaning undefined |
| upc | output | 8 | Current micro-program counter |
| instr_done | output | 1 | High in the cycle after upc was loaded with 0 |
| illegal_op | output | 1 | Sticky undefined-opcode error |

## Verification
Every result of this block is due one edge after its stimulus. The new `upc`, `instr_done` and `illegal_op` all come from the edge that samples the controls, the zero flag, the opcode and any pending write. The bench drives inputs just after a falling edge and compares all three outputs at the next falling edge, against a model it updates once per step. That model applies the writes of a step only after the step's own prediction, which covers the rule that a same-cycle read returns old contents. Every micro-address is reached through dispatch and then taken down each branch path, with both values of the zero flag.

// File: rtl/useq_pkg.sv
// Shared types for the micro-sequencer.
// Assumes: none beyond a two-bit encoding being enough for the sources.
package useq_pkg;

    // Where the next micro-address is taken from
    typedef enum logic [1:0] {
        SRC_FIELD = 2'd0,   // next-address field of the current word
        SRC_INC   = 2'd1,   // current micro-address plus one
        SRC_DISP  = 2'd2    // opcode dispatch table
    } nsrc_e;

endpackage

// File: rtl/useq_store.sv
// Synchronous-write, combinational-read register array. It is used both
// for the control store (next-address fields) and for the dispatch table.
// Assumes: one write port and one read port. A same-cycle read of the
// word being written returns the old contents. Every word is cleared by
// the synchronous active-low reset.
module useq_store #(
    parameter int AW = 8,
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic [AW-1:0] wr_addr,
    input  logic [DW-1:0] wr_data,
    input  logic [AW-1:0] rd_addr,
    output logic [DW-1:0] rd_data
);
    localparam int DEPTH = 1 << AW;

    logic [DW-1:0] mem [DEPTH];

    // Clear on reset, otherwise store the written word at the edge
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) begin
                mem[i] <= '0;
            end
        end else if (wr_en) begin
            mem[wr_addr] <= wr_data;
        end
    end

    // Read port: contents as they stand before the next edge
    assign rd_data = mem[rd_addr];

endmodule

// File: rtl/useq_next_sel.sv
// Priority resolver for the next micro-address source.
// Dispatch wins over everything. Among the conditional controls the
// not-zero test wins over the zero test. A failed test selects the
// increment path, and no control at all selects the next-address field.
// Assumes: the dispatch entry is valid in the same cycle as dispatch_en.
module useq_next_sel #(
    parameter int AW = 8
) (
    input  logic                 dispatch_en,
    input  logic                 cond_nz_en,
    input  logic                 cond_z_en,
    input  logic                 z_flag,
    input  logic [AW-1:0]        disp_entry,
    output useq_pkg::nsrc_e      src,
    output logic                 undef_op
);
    import useq_pkg::*;

    // Pick the source in fixed priority order
    always_comb begin
        src      = SRC_FIELD;
        undef_op = 1'b0;
        if (dispatch_en) begin
            src      = SRC_DISP;
            undef_op = (disp_entry == '0);
        end else if (cond_nz_en) begin
            src = z_flag ? SRC_INC : SRC_FIELD;
        end else if (cond_z_en) begin
            src = z_flag ? SRC_FIELD : SRC_INC;
        end
    end

endmodule

// File: rtl/micro_sequencer.sv
// Micro-program counter with skip-style branching and opcode dispatch.
// Each cycle it reads the next-address field at the current micro-address
// and the dispatch entry for the opcode. It lets useq_next_sel choose
// among field, increment and dispatch, then registers the result.
// Micro-address 0 ends a macro-instruction.
// Assumes: synchronous active-low reset. The control store is
// 2**AW words deep and the dispatch table has 2**OPW entries.
module micro_sequencer #(
    parameter int AW  = 8,
    parameter int OPW = 8
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           z_flag,
    input  logic [OPW-1:0] opcode,
    input  logic           dispatch_en,
    input  logic           cond_nz_en,
    input  logic           cond_z_en,
    input  logic           cs_wr_en,
    input  logic [AW-1:0]  cs_wr_addr,
    input  logic [AW-1:0]  cs_wr_data,
    input  logic           dt_wr_en,
    input  logic [OPW-1:0] dt_wr_addr,
    input  logic [AW-1:0]  dt_wr_data,
    output logic [AW-1:0]  upc,
    output logic           instr_done,
    output logic           illegal_op
);
    import useq_pkg::*;

    logic [AW-1:0] field_rd;
    logic [AW-1:0] disp_rd;
    logic [AW-1:0] upc_nxt;
    nsrc_e         src_sel;
    logic          undef_hit;

    // Control store: next-address field per micro-address
    useq_store #(.AW(AW), .DW(AW)) u_cstore (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (cs_wr_en),
        .wr_addr (cs_wr_addr),
        .wr_data (cs_wr_data),
        .rd_addr (upc),
        .rd_data (field_rd)
    );

    // Dispatch table: entry micro-address per opcode
    useq_store #(.AW(OPW), .DW(AW)) u_dtable (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (dt_wr_en),
        .wr_addr (dt_wr_addr),
        .wr_data (dt_wr_data),
        .rd_addr (opcode),
        .rd_data (disp_rd)
    );

    // Source priority resolution
    useq_next_sel #(.AW(AW)) u_sel (
        .dispatch_en (dispatch_en),
        .cond_nz_en  (cond_nz_en),
        .cond_z_en   (cond_z_en),
        .z_flag      (z_flag),
        .disp_entry  (disp_rd),
        .src         (src_sel),
        .undef_op    (undef_hit)
    );

    // Next micro-address multiplexer
    always_comb begin
        unique case (src_sel)
            SRC_INC:  upc_nxt = upc + 1'b1;
            SRC_DISP: upc_nxt = disp_rd;
            default:  upc_nxt = field_rd;
        endcase
    end

    // Micro-PC register
    always_ff @(posedge clk) begin
        if (!rst_n) upc <= '0;
        else        upc <= upc_nxt;
    end

    // End-of-instruction flag: set whenever zero is loaded
    always_ff @(posedge clk) begin
        if (!rst_n) instr_done <= 1'b0;
        else        instr_done <= (upc_nxt == '0);
    end

    // Sticky undefined-opcode error
    always_ff @(posedge clk) begin
        if (!rst_n)         illegal_op <= 1'b0;
        else if (undef_hit) illegal_op <= 1'b1;
    end

endmodule

// File: rtl/useq_sva.sv
// Property checker for micro_sequencer, attached by bind below.
// Assumes: synchronous active-low reset on rst_n.
module useq_sva #(
    parameter int AW = 8
) (
    input logic          clk,
    input logic          rst_n,
    input logic          z_flag,
    input logic          dispatch_en,
    input logic          cond_nz_en,
    input logic          cond_z_en,
    input logic [AW-1:0] disp_entry,
    input logic [AW-1:0] upc,
    input logic          instr_done,
    input logic          illegal_op
);
    a_r1_reset_state: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (upc == '0 && !instr_done && !illegal_op));

    a_r3_nz_skip: assert property (@(posedge clk) disable iff (!rst_n)
        (cond_nz_en && !dispatch_en && z_flag) |=> (upc == AW'($past(upc) + 1'b1)));

    a_r4_z_skip: assert property (@(posedge clk) disable iff (!rst_n)
        (cond_z_en && !cond_nz_en && !dispatch_en && !z_flag)
        |=> (upc == AW'($past(upc) + 1'b1)));

    a_r6_undef_entry: assert property (@(posedge clk) disable iff (!rst_n)
        (dispatch_en && disp_entry == '0) |=> (illegal_op && upc == '0));

    a_r7_err_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        illegal_op |=> illegal_op);

    a_r8_done_at_zero: assert property (@(posedge clk) disable iff (!rst_n)
        instr_done |-> (upc == '0));

endmodule

bind micro_sequencer useq_sva #(.AW(AW)) u_useq_sva (
    .clk         (clk),
    .rst_n       (rst_n),
    .z_flag      (z_flag),
    .dispatch_en (dispatch_en),
    .cond_nz_en  (cond_nz_en),
    .cond_z_en   (cond_z_en),
    .disp_entry  (disp_rd),
    .upc         (upc),
    .instr_done  (instr_done),
    .illegal_op  (illegal_op)
);

// File: tb/test_micro_sequencer.sv
`timescale 1ns/1ps
module test_micro_sequencer;
    localparam int AW  = 8;
    localparam int OPW = 8;

    logic           clk = 1'b0;
    logic           rst_n = 1'b0;
    logic           z_flag = 1'b0;
    logic [OPW-1:0] opcode = '0;
    logic           dispatch_en = 1'b0, cond_nz_en = 1'b0, cond_z_en = 1'b0;
    logic           cs_wr_en = 1'b0, dt_wr_en = 1'b0;
    logic [AW-1:0]  cs_wr_addr = '0, cs_wr_data = '0, dt_wr_data = '0;
    logic [OPW-1:0] dt_wr_addr = '0;
    logic [AW-1:0]  upc;
    logic           instr_done, illegal_op;

    micro_sequencer #(.AW(AW), .OPW(OPW)) i_micro_sequencer (
        .clk(clk), .rst_n(rst_n), .z_flag(z_flag), .opcode(opcode),
        .dispatch_en(dispatch_en), .cond_nz_en(cond_nz_en), .cond_z_en(cond_z_en),
        .cs_wr_en(cs_wr_en), .cs_wr_addr(cs_wr_addr), .cs_wr_data(cs_wr_data),
        .dt_wr_en(dt_wr_en), .dt_wr_addr(dt_wr_addr), .dt_wr_data(dt_wr_data),
        .upc(upc), .instr_done(instr_done), .illegal_op(illegal_op)
    );

    always #10 clk = ~clk;

    int n_cmp = 0, n_bad = 0;
    bit done_flag = 0;
    logic [7:0] m_upc;
    bit         m_err;
    logic [7:0] cs_m [256];
    logic [7:0] dt_m [256];

    function automatic logic [7:0] cs_f(int a);
        return 8'((a * 37 + 11) & 255);
    endfunction

    function automatic logic [7:0] dt_f(int op);
        return 8'(op) ^ 8'h5A;
    endfunction

    task automatic chk(string req, string what, int act, int exp);
        n_cmp++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!done_flag) begin
            done_flag = 1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    endtask

    // One edge: called at a falling edge, drives, then checks at the next
    task automatic step(string req, bit dec, bit nz, bit zz, bit z, int op);
        logic [7:0] nx;
        bit e_err;
        e_err = m_err;
        if (dec) begin
            nx = dt_m[op];
            if (nx == 0) e_err = 1;
        end else if (nz) nx = z ? 8'(m_upc + 1) : cs_m[m_upc];
        else if (zz)     nx = z ? cs_m[m_upc] : 8'(m_upc + 1);
        else             nx = cs_m[m_upc];
        dispatch_en = dec; cond_nz_en = nz; cond_z_en = zz;
        z_flag = z; opcode = 8'(op);
        @(negedge clk);
        if (cs_wr_en) cs_m[cs_wr_addr] = cs_wr_data;
        if (dt_wr_en) dt_m[dt_wr_addr] = dt_wr_data;
        cs_wr_en = 0; dt_wr_en = 0;
        dispatch_en = 0; cond_nz_en = 0; cond_z_en = 0;
        m_upc = nx; m_err = e_err;
        chk(req, "upc", int'(upc), int'(nx));
        chk("R8", "instr_done", int'(instr_done), int'(nx == 0));
        chk("R7", "illegal_op", int'(illegal_op), int'(e_err));
    endtask

    // Reset for two edges, check reset state, leave rst_n high
    task automatic do_reset();
        @(negedge clk); rst_n = 0;
        @(negedge clk);
        @(negedge clk);
        chk("R1", "upc", int'(upc), 0);
        chk("R1", "instr_done", int'(instr_done), 0);
        chk("R1", "illegal_op", int'(illegal_op), 0);
        for (int i = 0; i < 256; i++) begin cs_m[i] = 0; dt_m[i] = 0; end
        m_upc = 0; m_err = 0;
        rst_n = 1;
    endtask

    initial begin
        #(20 * 150000);
        n_bad++;
        $display("FAIL watchdog: actual hung expected finish");
        finish_run();
    end

    initial begin
        do_reset();
        // R1: tables cleared, so any dispatch is illegal
        step("R1", 1, 0, 0, 0, 3);
        step("R2", 0, 0, 0, 0, 0);
        do_reset();
        // Fill both tables while running; R10 and R2 checked every step
        for (int a = 0; a < 256; a++) begin
            cs_wr_en = 1; cs_wr_addr = 8'(a); cs_wr_data = cs_f(a);
            dt_wr_en = 1; dt_wr_addr = 8'(a); dt_wr_data = dt_f(a);
            step("R10", 0, 0, 0, 0, 0);
        end
        // Every reachable micro-address down every path
        for (int op = 0; op < 256; op++) begin
            if (op == 'h5A) continue;
            step("R5", 1, 0, 0, 0, op);
            step("R2", 0, 0, 0, 0, 0);
            step("R5", 1, 0, 0, 0, op);
            step("R3", 0, 1, 0, 0, 0);
            step("R5", 1, 0, 0, 0, op);
            step("R3", 0, 1, 0, 1, 0);
            step("R5", 1, 0, 0, 0, op);
            step("R4", 0, 0, 1, 1, 0);
            step("R5", 1, 0, 0, 0, op);
            step("R4", 0, 0, 1, 0, 0);
            step("R5", 1, 0, 0, 0, op);
            step("R9", 0, 1, 1, 1, 0);
            step("R9", 1, 1, 1, 1, op);
            step("R9", 0, 1, 1, 0, 0);
            step("R9", 1, 1, 0, 0, op);
        end
        // Same-cycle write and read of the current word (R10)
        step("R5", 1, 0, 0, 0, 'h4A);
        cs_wr_en = 1; cs_wr_addr = m_upc; cs_wr_data = 8'h77;
        step("R10", 0, 0, 0, 0, 0);
        step("R5", 1, 0, 0, 0, 'h4A);
        step("R10", 0, 0, 0, 0, 0);
        // Undefined opcode and stickiness
        step("R6", 1, 0, 0, 0, 'h5A);
        step("R6", 0, 0, 0, 0, 0);
        step("R7", 1, 0, 0, 0, 'h11);
        step("R7", 0, 1, 0, 1, 0);
        do_reset();
        step("R2", 0, 0, 0, 0, 0);
        finish_run();
    end
endmodule